// File: doc/BRIEF.md
# Conversion Window Monitor

This block observes each finished conversion result and raises a sticky out-of-range flag when the value lies above a high limit or below a low limit. Software programs both limits. The check runs on the raw result, before any alignment or resolution formatting is applied. The alignment setting therefore never changes which values trip the flag.

A scope bit selects the channels that are checked. The monitor can check results from every channel, or only results that carry one chosen channel number. The flag stays set until software clears it by writing one. An interrupt output follows the flag while its enable bit is on.

The control is a three-state machine:
- MON_OFF: the monitor is disabled, which is the reset state.
- MON_ARMED: the monitor is enabled and the flag is clear.
- MON_TRIPPED: the flag is set.

Transitions:
- ENABLE moves MON_OFF to MON_ARMED when the enable input is high.
- DISABLE moves MON_ARMED to MON_OFF when the enable input is low.
- TRIP moves any state to MON_TRIPPED on a qualifying out-of-window result.
- CLEAR moves MON_TRIPPED to MON_ARMED, or to MON_OFF if the monitor is disabled, on a clear pulse with no trip in the same cycle.

Top module: `window_monitor`

## Requirements
- R1: After reset, and whenever reset is asserted, `oor_flag` and `irq` are 0.
- R2: While `mon_en` is 0, no result sets `oor_flag`.
- R3: An enabled, qualifying result with `res_value` strictly greater than `thr_hi` sets `oor_flag` on the following clock edge.
- R4: An enabled, qualifying result with `res_value` strictly less than `thr_lo` sets `oor_flag` on the following clock edge.
- R5: A value equal to `thr_hi`, equal to `thr_lo`, or between them does not set `oor_flag`.
- R6: With `single_sel` = 0, results on every channel number, including the highest, are checked.
- R7: With `single_sel` = 1, only results whose `res_chan` equals `sel_chan` are checked. Results on other channels never affect `oor_flag`.
- R8: `oor_flag` stays set until a one is written on `flag_clr`. After a clear with no trip in the same cycle, the flag reads 0 on the next edge. The flag also stays set after the monitor is disabled.
- R9: When a trip and `flag_clr` occur in the same cycle, the trip wins and `oor_flag` stays set.
- R10: `irq` is 1 exactly when `oor_flag` is 1 and `irq_en` is 1. `irq` follows `irq_en` in the same cycle.
- R11: A cycle with `res_valid` = 0 never sets `oor_flag`, whatever `res_value` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | One-cycle pulse: a conversion result is present |
| res_chan | input | CHAN_W | Channel number of the result |
| res_value | input | DATA_W | Raw, unaligned result value |
| mon_en | input | 1 | Monitor enable |
| single_sel | input | 1 | 1: check only `sel_chan`; 0: check all channels |
| sel_chan | input | CHAN_W | Channel checked in single-channel scope |
| thr_hi | input | DATA_W | Upper limit (inclusive inside) |
| thr_lo | input | DATA_W | Lower limit (inclusive inside) |
| flag_clr | input | 1 | Write-one pulse that clears the flag |
| irq_en | input | 1 | Interrupt enable |
| oor_flag | output | 1 | Sticky out-of-window flag |
| irq | output | 1 | Flag gated by `irq_en` |

## Verification
The bench builds the monitor with its default widths: a 12-bit result and a 5-bit channel number. These widths let the stimulus reach the extreme codes 0x000 and 0xFFF. They also reach the top channel number, 31, in all-channel scope. Limits of 0x200 and 0xC00 sit well inside the code range. This placement puts the values one step either side of each limit, and the limits themselves, within reach of the test. The single-channel tests choose channel 5 and place traffic on channels 4 and 6 around it, so a miscompared channel number shows up.

// File: rtl/window_monitor_pkg.sv
package window_monitor_pkg;

    typedef enum logic [1:0] {
        MON_OFF     = 2'd0,
        MON_ARMED   = 2'd1,
        MON_TRIPPED = 2'd2
    } mon_state_e;

endpackage

// File: rtl/wm_chan_filter.sv
module wm_chan_filter #(
    parameter int CHAN_W = 5
) (
    input  logic              single_sel,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic [CHAN_W-1:0] sel_chan,
    output logic              chan_ok
);
    // In all-channel scope every result qualifies; otherwise only the chosen one.
    always_comb begin
        if (single_sel) chan_ok = (res_chan == sel_chan);
        else            chan_ok = 1'b1;
    end
endmodule

// File: rtl/wm_window_cmp.sv
module wm_window_cmp #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] lim_hi,
    input  logic [DATA_W-1:0] lim_lo,
    output logic              outside
);
    logic above;
    logic below;

    // Limits themselves count as inside the window.
    always_comb begin
        above   = (value > lim_hi);
        below   = (value < lim_lo);
        outside = above | below;
    end
endmodule

// File: rtl/wm_fsm.sv
module wm_fsm
    import window_monitor_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mon_en,
    input  logic trip,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    mon_state_e state_q;
    mon_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (trip) begin
            state_d = MON_TRIPPED;                      // TRIP has priority
        end else begin
            unique case (state_q)
                MON_OFF:     if (mon_en)  state_d = MON_ARMED;   // ENABLE
                MON_ARMED:   if (!mon_en) state_d = MON_OFF;     // DISABLE
                MON_TRIPPED: if (clr)     state_d = mon_en ? MON_ARMED : MON_OFF; // CLEAR
                default:                  state_d = MON_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MON_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = 1'b0;
        irq  = 1'b0;
        unique case (state_q)
            MON_OFF, MON_ARMED: begin
                flag = 1'b0;
                irq  = 1'b0;
            end
            MON_TRIPPED: begin
                flag = 1'b1;
                irq  = irq_en;
            end
            default: begin
                flag = 1'b0;
                irq  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/window_monitor.sv
module window_monitor #(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic [DATA_W-1:0] res_value,
    input  logic              mon_en,
    input  logic              single_sel,
    input  logic [CHAN_W-1:0] sel_chan,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic              flag_clr,
    input  logic              irq_en,
    output logic              oor_flag,
    output logic              irq
);
    logic chan_ok;
    logic outside;
    logic trip;

    wm_chan_filter #(.CHAN_W(CHAN_W)) u_filt (
        .single_sel (single_sel),
        .res_chan   (res_chan),
        .sel_chan   (sel_chan),
        .chan_ok    (chan_ok)
    );

    wm_window_cmp #(.DATA_W(DATA_W)) u_cmp (
        .value   (res_value),
        .lim_hi  (thr_hi),
        .lim_lo  (thr_lo),
        .outside (outside)
    );

    assign trip = res_valid & mon_en & chan_ok & outside;

    wm_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .mon_en (mon_en),
        .trip   (trip),
        .clr    (flag_clr),
        .irq_en (irq_en),
        .flag   (oor_flag),
        .irq    (irq)
    );
endmodule

// File: rtl/window_monitor_checker.sv
module window_monitor_checker #(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [CHAN_W-1:0] res_chan,
    input logic [DATA_W-1:0] res_value,
    input logic              mon_en,
    input logic              single_sel,
    input logic [CHAN_W-1:0] sel_chan,
    input logic [DATA_W-1:0] thr_hi,
    input logic [DATA_W-1:0] thr_lo,
    input logic              flag_clr,
    input logic              irq_en,
    input logic              oor_flag,
    input logic              irq
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !oor_flag); // R1
    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!oor_flag && !mon_en) |=> !oor_flag); // R2
    AST_HI_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && res_valid && !single_sel && res_value > thr_hi) |=> oor_flag); // R3
    AST_LO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && res_valid && !single_sel && res_value < thr_lo) |=> oor_flag); // R4
    AST_INSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!oor_flag && res_value <= thr_hi && res_value >= thr_lo) |=> !oor_flag); // R5
    AST_OTHER_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (!oor_flag && single_sel && res_chan != sel_chan) |=> !oor_flag); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (oor_flag && !flag_clr) |=> oor_flag); // R8
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (oor_flag && flag_clr && !res_valid) |=> !oor_flag); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (oor_flag && irq_en)); // R10
    AST_NO_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!oor_flag && !res_valid) |=> !oor_flag); // R11
endmodule

bind window_monitor window_monitor_checker #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_chan   (res_chan),
    .res_value  (res_value),
    .mon_en     (mon_en),
    .single_sel (single_sel),
    .sel_chan   (sel_chan),
    .thr_hi     (thr_hi),
    .thr_lo     (thr_lo),
    .flag_clr   (flag_clr),
    .irq_en     (irq_en),
    .oor_flag   (oor_flag),
    .irq        (irq)
);

// File: tb/sim_window_monitor.sv
`timescale 1ns/1ps
module sim_window_monitor;
    localparam int DW = 12;
    localparam int CW = 5;

    typedef struct packed {
        logic          en;
        logic          single;
        logic [CW-1:0] selch;
        logic          valid;
        logic [CW-1:0] ch;
        logic [DW-1:0] val;
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic          clr;
        logic          irqen;
        logic          xflag;
    } vec_t;

    localparam int NV = 18;
    // fields: en single selch valid ch val hi lo clr irqen expected_flag
    localparam vec_t TBL [0:NV-1] = '{
        '{1'b0,1'b0,5'd0,1'b1,5'd3, 12'hFFF,12'hC00,12'h200,1'b0,1'b0,1'b0}, // R2 disabled
        '{1'b1,1'b0,5'd0,1'b1,5'd3, 12'h800,12'hC00,12'h200,1'b0,1'b0,1'b0}, // R5 inside
        '{1'b1,1'b0,5'd0,1'b1,5'd3, 12'hC00,12'hC00,12'h200,1'b0,1'b0,1'b0}, // R5 equal hi
        '{1'b1,1'b0,5'd0,1'b1,5'd3, 12'h200,12'hC00,12'h200,1'b0,1'b0,1'b0}, // R5 equal lo
        '{1'b1,1'b0,5'd0,1'b1,5'd3, 12'hC01,12'hC00,12'h200,1'b0,1'b1,1'b1}, // R3 R10
        '{1'b1,1'b0,5'd0,1'b0,5'd3, 12'h000,12'hC00,12'h200,1'b0,1'b0,1'b1}, // R8 sticky, R10 gated
        '{1'b1,1'b0,5'd0,1'b0,5'd3, 12'h000,12'hC00,12'h200,1'b1,1'b1,1'b0}, // R8 clear
        '{1'b1,1'b0,5'd0,1'b1,5'd31,12'h1FF,12'hC00,12'h200,1'b0,1'b0,1'b1}, // R4 R6
        '{1'b1,1'b0,5'd0,1'b1,5'd2, 12'h000,12'hC00,12'h200,1'b1,1'b1,1'b1}, // R9
        '{1'b1,1'b0,5'd0,1'b0,5'd2, 12'h000,12'hC00,12'h200,1'b1,1'b0,1'b0}, // R8
        '{1'b1,1'b1,5'd5,1'b1,5'd4, 12'hFFF,12'hC00,12'h200,1'b0,1'b1,1'b0}, // R7 other
        '{1'b1,1'b1,5'd5,1'b1,5'd6, 12'h000,12'hC00,12'h200,1'b0,1'b1,1'b0}, // R7 other
        '{1'b1,1'b1,5'd5,1'b1,5'd5, 12'h100,12'hC00,12'h200,1'b0,1'b1,1'b1}, // R7 selected
        '{1'b1,1'b1,5'd5,1'b1,5'd6, 12'h000,12'hC00,12'h200,1'b1,1'b0,1'b0}, // R7 R8
        '{1'b1,1'b0,5'd0,1'b0,5'd1, 12'hFFF,12'hC00,12'h200,1'b0,1'b1,1'b0}, // R11
        '{1'b1,1'b0,5'd0,1'b1,5'd1, 12'hFFF,12'hC00,12'h200,1'b0,1'b1,1'b1}, // R3
        '{1'b0,1'b0,5'd0,1'b0,5'd1, 12'h000,12'hC00,12'h200,1'b0,1'b1,1'b1}, // R8 kept when disabled
        '{1'b0,1'b0,5'd0,1'b1,5'd1, 12'h000,12'hC00,12'h200,1'b1,1'b0,1'b0}  // R2 R8
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          res_valid = 1'b0;
    logic [CW-1:0] res_chan = '0;
    logic [DW-1:0] res_value = '0;
    logic          mon_en = 1'b0;
    logic          single_sel = 1'b0;
    logic [CW-1:0] sel_chan = '0;
    logic [DW-1:0] thr_hi = '0;
    logic [DW-1:0] thr_lo = '0;
    logic          flag_clr = 1'b0;
    logic          irq_en = 1'b0;
    logic          oor_flag;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    window_monitor #(.DATA_W(DW), .CHAN_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_value(res_value), .mon_en(mon_en), .single_sel(single_sel),
        .sel_chan(sel_chan), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .flag_clr(flag_clr), .irq_en(irq_en), .oor_flag(oor_flag), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        mon_en     = v.en;
        single_sel = v.single;
        sel_chan   = v.selch;
        res_valid  = v.valid;
        res_chan   = v.ch;
        res_value  = v.val;
        thr_hi     = v.hi;
        thr_lo     = v.lo;
        flag_clr   = v.clr;
        irq_en     = v.irqen;
    endtask

    task automatic idle_inputs();
        res_valid = 1'b0;
        flag_clr  = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        irq_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "flag in reset", oor_flag, 1'b0);
        check("R1", "irq in reset", irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flag after reset", oor_flag, 1'b0);

        // Table walk: each vector is held for one edge, results sampled at the next falling edge.
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            @(negedge clk);
            check("R2-R11 table", $sformatf("flag vec %0d", i), oor_flag, TBL[i].xflag);
            check("R10", $sformatf("irq vec %0d", i), irq, TBL[i].xflag & TBL[i].irqen);
        end

        // R1: reset while tripped clears flag and irq.
        apply(TBL[15]);
        @(negedge clk);
        idle_inputs();
        check("R3", "trip before reset", oor_flag, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "flag after mid-run reset", oor_flag, 1'b0);
        check("R1", "irq after mid-run reset", irq, 1'b0);
        rst_n = 1'b1;

        // R5: window at full range never trips on extreme codes.
        mon_en = 1'b1; single_sel = 1'b0; thr_hi = 12'hFFF; thr_lo = 12'h000;
        res_valid = 1'b1; res_value = 12'hFFF;
        @(negedge clk);
        res_value = 12'h000;
        @(negedge clk);
        idle_inputs();
        check("R5", "full-range window", oor_flag, 1'b0);

        // R10: irq follows irq_en in the same cycle while flag held.
        thr_hi = 12'h010; res_valid = 1'b1; res_value = 12'h011; irq_en = 1'b0;
        @(negedge clk);
        idle_inputs();
        check("R3", "one above hi", oor_flag, 1'b1);
        check("R10", "irq masked", irq, 1'b0);
        irq_en = 1'b1;
        #1;
        check("R10", "irq unmasked same cycle", irq, 1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule